// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds an 8-bit word that is captured from a parallel bus and then sent out one bit at a time, starting with the most significant bit. It runs on a fast system clock. The two external shift-clock pins are not used as clocks. They are sampled through synchronizers, and a shift is triggered by a detected rising edge of their logical OR. Because the clocks are combined by OR, holding either pin high blocks all shifting from the other. Each pin can therefore act as an active-low shift enable for its partner, or the two pins can come from independent sources.

The load strobe is active low and level-sensitive. While it is held low, the register copies the parallel bus on every system clock, and any shift-clock activity is discarded. The serial output is taken from the top bit of the register, and a complemented copy is driven beside it. New data enters at the bottom bit on every shift.

Top module: `piso_shift_reg`

## Requirements
- R1: While `parLoadN` is 0 at a system clock edge, the register takes `parIn` at that edge, whatever the levels of the shift clocks.
- R2: No shift takes place at any edge where `parLoadN` is 0, even if a rising edge of the shift clocks is detected.
- R3: `serialOut` is register bit 7. After a load, it shows `parIn[7]` first, then `parIn[6]`, and so on.
- R4: `serialOutN` is always the inverse of `serialOut`.
- R5: On each shift, `serialIn` enters at bit 0 and every bit moves one place toward bit 7.
- R6: A 0-to-1 change of (`shiftClkA` OR `shiftClkB`) causes exactly one shift. The output changes three system clock edges after the input change. A clock held high gives no further shifts.
- R7: While either shift clock is held at 1, pulses on the other clock cause no shift.
- R8: Lowering a shift clock never causes a shift, whether the other clock is high or low. A later rise on the remaining clock, made while both are low beforehand, shifts once.
- R9: When `parLoadN` returns to 1 while a shift clock is already high, no shift follows until that OR has fallen and risen again.
- R10: Synchronous reset clears the register to 0x00, so `serialOut` is 0 and `serialOutN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| parIn | input | 8 | Parallel data word |
| parLoadN | input | 1 | Level-sensitive parallel load, active low |
| serialIn | input | 1 | Serial data entering at bit 0 |
| shiftClkA | input | 1 | First shift clock, sampled |
| shiftClkB | input | 1 | Second shift clock, sampled |
| serialOut | output | 1 | Register bit 7 |
| serialOutN | output | 1 | Inverse of register bit 7 |

## Verification
A load made at one edge is visible on the outputs right after that edge. A shift-clock change passes through two synchronizer stages and the edge detector, so its result shows only after the third system clock edge. The bench drives every input on the falling edge and waits four full cycles after each shift-clock change before sampling, which leaves one cycle of margin. For the cases where no shift is expected, the bench waits the same number of cycles. The output is then compared with its value before the stimulus, so a late shift cannot be mistaken for no shift.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic loadNow;
    logic shiftNow;
  } shiftCtrl_t;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   parLoadN,
  input  logic                   shiftClkA,
  input  logic                   shiftClkB,
  output piso_pkg::shiftCtrl_t   strobes
);
  localparam int NUM_CLK = 2;

  logic [NUM_CLK-1:0] rawClk;
  logic [NUM_CLK-1:0] syncClk;
  logic orNow;
  logic orPrev;

  assign rawClk = {shiftClkB, shiftClkA};

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_sync
    piso_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .asyncIn(rawClk[i]),
      .syncOut(syncClk[i])
    );
  end

  assign orNow = |syncClk;

  // History always follows the OR, so after a load a level that is already
  // high counts as old and does not fire a shift.
  always_ff @(posedge clk) begin
    if (rst) orPrev <= 1'b0;
    else     orPrev <= orNow;
  end

  always_comb begin
    strobes.loadNow  = ~parLoadN;
    strobes.shiftNow = parLoadN & orNow & ~orPrev;
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath #(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  piso_pkg::shiftCtrl_t strobes,
  input  logic [WIDTH-1:0]     parIn,
  input  logic                 serialIn,
  output logic [WIDTH-1:0]     dataQ
);
  always_ff @(posedge clk) begin
    if (rst)                   dataQ <= '0;
    else if (strobes.loadNow)  dataQ <= parIn;
    else if (strobes.shiftNow) dataQ <= {dataQ[WIDTH-2:0], serialIn};
  end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] parIn,
  input  logic             parLoadN,
  input  logic             serialIn,
  input  logic             shiftClkA,
  input  logic             shiftClkB,
  output logic             serialOut,
  output logic             serialOutN
);
  localparam int TOP = WIDTH - 1;

  piso_pkg::shiftCtrl_t ctrlStrb;
  logic [WIDTH-1:0]     dataQ;

  piso_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .parLoadN (parLoadN),
    .shiftClkA(shiftClkA),
    .shiftClkB(shiftClkB),
    .strobes  (ctrlStrb)
  );

  piso_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (ctrlStrb),
    .parIn   (parIn),
    .serialIn(serialIn),
    .dataQ   (dataQ)
  );

  assign serialOut  = dataQ[TOP];
  assign serialOutN = ~dataQ[TOP];
endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
  parameter int WIDTH = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 parLoadN,
  input logic [WIDTH-1:0]     parIn,
  input logic                 serialIn,
  input piso_pkg::shiftCtrl_t strobes,
  input logic [WIDTH-1:0]     dataQ
);
  AST_PAR_LOAD: assert property (@(posedge clk) disable iff (rst)
    !parLoadN |=> dataQ == $past(parIn)); // R1

  AST_LOAD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !parLoadN |-> !strobes.shiftNow); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    (parLoadN && strobes.shiftNow) |=>
      dataQ == {$past(dataQ[WIDTH-2:0]), $past(serialIn)}); // R5

  AST_ONE_SHIFT_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftNow |=> !strobes.shiftNow); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (parLoadN && !strobes.shiftNow) |=> $stable(dataQ)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> dataQ == '0); // R10
endmodule

bind piso_shift_reg piso_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .parLoadN(parLoadN),
  .parIn   (parIn),
  .serialIn(serialIn),
  .strobes (ctrlStrb),
  .dataQ   (dataQ)
);

// File: tb/tb_piso_shift_reg.sv
module tb_piso_shift_reg;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int NVEC       = 6;
  // {load byte, clock select (1=A, 2=B, 3=both), serial pattern}
  localparam logic [17:0] VECS [NVEC] = '{
    {8'hA5, 2'd1, 8'h3C}, {8'h5A, 2'd2, 8'hC3}, {8'hF0, 2'd3, 8'h0F},
    {8'h81, 2'd1, 8'h7E}, {8'h00, 2'd2, 8'hFF}, {8'hFF, 2'd3, 8'h00}
  };

  logic clk = 1'b0;
  logic rst, parLoadN, serialIn, shiftClkA, shiftClkB;
  logic [7:0] parIn;
  logic serialOut, serialOutN;
  logic [7:0] model;
  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  piso_shift_reg dut (
    .clk(clk), .rst(rst), .parIn(parIn), .parLoadN(parLoadN),
    .serialIn(serialIn), .shiftClkA(shiftClkA), .shiftClkB(shiftClkB),
    .serialOut(serialOut), .serialOutN(serialOutN)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req);
    check(req, serialOut, model[7]);
    check({req, " (R4)"}, serialOutN, ~model[7]);
  endtask

  task automatic loadByte(input logic [7:0] b);
    parIn = b; parLoadN = 1'b0;
    waitCyc(2);
    parLoadN = 1'b1;
    waitCyc(1);
    model = b;
  endtask

  task automatic pulse(input logic [1:0] sel, input logic bitIn);
    serialIn = bitIn;
    shiftClkA = sel[0]; shiftClkB = sel[1];
    waitCyc(SETTLE);
    shiftClkA = 1'b0; shiftClkB = 1'b0;
    waitCyc(SETTLE);
    model = {model[6:0], bitIn};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; parLoadN = 1'b1; serialIn = 1'b0;
    shiftClkA = 1'b0; shiftClkB = 1'b0; parIn = 8'h00;
    waitCyc(3);
    model = 8'h00;
    checkOut("R10 reset clears");
    rst = 1'b0;
    waitCyc(2);

    // Table walk: R1, R3, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      loadByte(VECS[v][17:10]);
      checkOut("R1/R3 first bit after load");
      for (int i = 0; i < 16; i++) begin
        pulse(VECS[v][9:8], (i < 8) ? VECS[v][7-i] : 1'b0);
        checkOut("R5/R6 shift stream");
      end
    end

    // R2: clock edges during load are discarded
    loadByte(8'h6D);
    parLoadN = 1'b0; parIn = 8'h6D;
    shiftClkA = 1'b1; waitCyc(SETTLE);
    shiftClkA = 1'b0; waitCyc(SETTLE);
    parLoadN = 1'b1; waitCyc(SETTLE);
    checkOut("R2 no shift while loading");
    pulse(2'd1, 1'b0);
    checkOut("R2 next bit after load");

    // R7: B held high blocks A pulses
    shiftClkB = 1'b1; waitCyc(SETTLE);
    model = {model[6:0], serialIn};
    checkOut("R7 rise of B shifts once");
    for (int k = 0; k < 3; k++) begin
      shiftClkA = 1'b1; waitCyc(SETTLE);
      shiftClkA = 1'b0; waitCyc(SETTLE);
      checkOut("R7 A blocked while B high");
    end

    // R8: lowering a clock never shifts
    shiftClkA = 1'b1; waitCyc(SETTLE);
    shiftClkB = 1'b0; waitCyc(SETTLE);
    checkOut("R8 release B with A high");
    shiftClkA = 1'b0; waitCyc(SETTLE);
    checkOut("R8 release A with B low");
    serialIn = 1'b1;
    shiftClkA = 1'b1; waitCyc(SETTLE);
    model = {model[6:0], 1'b1};
    checkOut("R8 rise after release shifts");
    shiftClkA = 1'b0; waitCyc(SETTLE);

    // R9: clock already high when load ends
    shiftClkB = 1'b1; waitCyc(SETTLE);
    model = {model[6:0], serialIn};
    parIn = 8'h4B; parLoadN = 1'b0; waitCyc(2);
    parLoadN = 1'b1; model = 8'h4B;
    waitCyc(SETTLE);
    checkOut("R9 no shift on release with clock high");
    shiftClkB = 1'b0; waitCyc(SETTLE);
    pulse(2'd2, 1'b0);
    checkOut("R9 next rise shifts");

    // R10: reset mid-stream
    loadByte(8'hFF);
    rst = 1'b1; waitCyc(1); rst = 1'b0;
    model = 8'h00;
    checkOut("R10 reset after load");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule